// File: doc/BRIEF.md
# Byte-Packed PWM Timer

This block turns a free-running timer counter into an 8-bit pulse-width modulator. A single compare word holds two bytes. The upper byte is the high time: the number of counter steps per period during which the output is 1. The lower byte is the top count: the counter runs from 0 up to this value and then wraps, so a period lasts top count plus one steps. The counter advances on each clock where the block is enabled and the tick input is high. Software reaches the block through a small write port that selects the control bit, the compare word or the counter.

Several compare combinations do not describe a normal pulse, and the block forces the output to a constant for them. A top count of zero gives a steady 0, and so does a high time of zero. A high time larger than the top count gives a steady 1. New compare values apply at once and are not buffered. To change the pulse cleanly, a user disables the block, writes the compare word, clears the counter and then enables the block again.

Top module: `dual_byte_pwm`

## Requirements
- R1: After reset the block is disabled, the compare word and the counter are zero, and `pwm_out` is 0. Enabling the block without writing a compare word keeps the output at 0.
- R2: The counter advances only on clocks where the enable bit and `tick` are both 1. It wraps to 0 on a step taken at the top count, so with ticks on every other clock one period lasts twice as many clocks.
- R3: While disabled, the counter keeps its value and `pwm_out` is 0. After re-enabling, counting resumes from the held value.
- R4: When the top count P is between 1 and 254 and the high time D is between 1 and P, the output is 1 for counter values 0 to D-1 and 0 for values D to P. That is D high steps in every P+1 steps.
- R5: When P is 0, the output is constantly 0 for every D.
- R6: When D is 0, the output is constantly 0 for every P.
- R7: When P is 255, the period is 256 steps, and any D from 1 to 255 gives D high steps per period.
- R8: When D equals P+1 and P is at least 1, the output is constantly 1.
- R9: When D is larger than P+1, the output is constantly 1.
- R10: A write with `wr_en`=1 acts on the next clock edge. `wr_sel` 0 loads the enable from `wr_data[0]`. `wr_sel` 1 loads the compare word, with D in `wr_data[15:8]` and P in `wr_data[7:0]`. `wr_sel` 2 loads the counter from `wr_data`. `wr_sel` 3 has no effect. A counter load takes priority over a step.
- R11: `pwm_out` is registered. In the clock after an enabled edge, it shows the level for the counter value held at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_sel | input | 2 | Write target: 0 enable, 1 compare word, 2 counter, 3 none |
| wr_data | input | 16 | Write data |
| tick | input | 1 | Count-enable pulse |
| pwm_out | output | 1 | Modulated output |

## Verification
The main function is driven with ordinary duty settings of 1, the midpoint and the full top count. These separate the wrap and match positions, because an off-by-one in either one shifts the number of high steps per window. The degenerate settings are also driven: a zero top count, a zero high time, a high time of exactly top plus one, and a high time far above the top. These show whether each forced constant wins over the plain comparison. A 256-step period tests the case where the top count is all ones. Ticks on alternate clocks tell gated counting apart from free counting. A disable in the middle of a period shows whether the counter holds its value or restarts.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   // write-port target codes; the bench and the requirements rely on these values
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_CMP  = 2'd1,
      SEL_CNT  = 2'd2,
      SEL_NONE = 2'd3
   } dbp_sel_e;

   // classification of the compare word
   typedef enum logic [1:0] {
      MODE_OFF = 2'd0,
      MODE_ON  = 2'd1,
      MODE_PWM = 2'd2
   } dbp_mode_e;
endpackage

// File: rtl/dbp_regs.sv
module dbp_regs
   import dbp_pkg::*;
#(
   parameter int PWM_W = 8,
   parameter int DW    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [DW-1:0]    wr_data,
   output logic             en_o,
   output logic [PWM_W-1:0] duty_o,
   output logic [PWM_W-1:0] per_o,
   output logic             cnt_ld_o,
   output logic [DW-1:0]    cnt_ld_val_o
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int CMP_W = 2 * PWM_W;

   dbp_sel_e         sel;
   logic             en_q;
   logic [CMP_W-1:0] cmp_q;

   assign sel = dbp_sel_e'(wr_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         cmp_q <= '0;
      end else if (wr_en) begin
         case (sel)
            SEL_CTRL: en_q  <= wr_data[0];
            SEL_CMP:  cmp_q <= wr_data[CMP_W-1:0];
            default:  ;
         endcase
      end
   end

   assign en_o         = en_q;
   assign duty_o       = cmp_q[CMP_W-1:PWM_W];
   assign per_o        = cmp_q[PWM_W-1:0];
   assign cnt_ld_o     = wr_en && (sel == SEL_CNT);
   assign cnt_ld_val_o = wr_data;

   // R10: the compare word takes the written value on the next edge
   a_r10_cmp_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1) |=> ({duty_o, per_o} == $past(wr_data[CMP_W-1:0])));

   // R10: the reserved code leaves enable and compare untouched
   a_r10_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd3) |=> ($stable(en_o) && $stable(duty_o) && $stable(per_o)));
endmodule

// File: rtl/dbp_counter.sv
module dbp_counter #(
   parameter int CNT_W = 16,
   parameter int PWM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic [PWM_W-1:0] per,
   output logic [CNT_W-1:0] cnt_o
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] top;
   logic             step;
   logic             at_top;

   assign top    = CNT_W'(per);
   assign step   = en && tick;
   assign at_top = (cnt_q == top);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (ld)    cnt_q <= ld_val;
      else if (step)  cnt_q <= at_top ? '0 : cnt_q + ONE;
   end

   assign cnt_o = cnt_q;

   // R2/R3: without a qualified step or a load the count holds
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !(en && tick)) |=> $stable(cnt_o));

   // R2: a step at the top count wraps to zero
   a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && en && tick && cnt_o == CNT_W'(per)) |=> (cnt_o == '0));

   // R2: a step below the top count adds one
   a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && en && tick && cnt_o < CNT_W'(per)) |=> (cnt_o == $past(cnt_o) + ONE));

   // R10: a load wins over a step
   a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (cnt_o == $past(ld_val)));
endmodule

// File: rtl/dbp_wave.sv
module dbp_wave
   import dbp_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int PWM_W   = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] cnt,
   input  logic [PWM_W-1:0] duty,
   input  logic [PWM_W-1:0] per,
   output logic             pwm_o
);
   timeunit 1ns;
   timeprecision 100ps;

   dbp_mode_e mode;
   logic      below_duty;
   logic      level;

   // degenerate words are forced before the plain comparison
   always_comb begin
      if (per == '0 || duty == '0) mode = MODE_OFF;
      else if (duty > per)         mode = MODE_ON;
      else                         mode = MODE_PWM;
   end

   assign below_duty = (cnt < CNT_W'(duty));

   always_comb begin
      unique case (mode)
         MODE_ON:  level = en;
         MODE_PWM: level = en && below_duty;
         default:  level = 1'b0;
      endcase
   end

   if (OUT_REG) begin : g_reg
      logic out_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) out_q <= 1'b0;
         else        out_q <= level;
      end
      assign pwm_o = out_q;

      // R3: disabled means low output
      a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
         !en |=> !pwm_o);
      // R5: zero top count forces low
      a_r5_period_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (per == '0) |=> !pwm_o);
      // R6: zero high time forces low
      a_r6_duty_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (duty == '0) |=> !pwm_o);
      // R8/R9: high time above top count forces high
      a_r8_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
         (en && per != '0 && duty > per) |=> pwm_o);
      // R4: counter at zero sets the output
      a_r4_set_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (en && per != '0 && duty != '0 && cnt == '0) |=> pwm_o);
      // R4: counter at the high time clears the output
      a_r4_clear_at_match: assert property (@(posedge clk) disable iff (!rst_n)
         (en && duty != '0 && duty <= per && cnt == CNT_W'(duty)) |=> !pwm_o);
   end else begin : g_comb
      assign pwm_o = level;
   end
endmodule

// File: rtl/dual_byte_pwm.sv
module dual_byte_pwm #(
   parameter int PWM_W   = 8,
   parameter int CNT_W   = 16,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             tick,
   output logic             pwm_out
);
   timeunit 1ns;
   timeprecision 100ps;

   if (PWM_W < 2) begin : g_bad_pwm_w
      $error("dual_byte_pwm: PWM_W must be at least 2");
   end
   if (CNT_W < 2 * PWM_W) begin : g_bad_cnt_w
      $error("dual_byte_pwm: CNT_W must hold the whole compare word");
   end

   logic             en;
   logic [PWM_W-1:0] duty;
   logic [PWM_W-1:0] per;
   logic             cnt_ld;
   logic [CNT_W-1:0] cnt_ld_val;
   logic [CNT_W-1:0] cnt;

   dbp_regs #(.PWM_W(PWM_W), .DW(CNT_W)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_sel       (wr_sel),
      .wr_data      (wr_data),
      .en_o         (en),
      .duty_o       (duty),
      .per_o        (per),
      .cnt_ld_o     (cnt_ld),
      .cnt_ld_val_o (cnt_ld_val)
   );

   dbp_counter #(.CNT_W(CNT_W), .PWM_W(PWM_W)) u_counter (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .tick   (tick),
      .ld     (cnt_ld),
      .ld_val (cnt_ld_val),
      .per    (per),
      .cnt_o  (cnt)
   );

   dbp_wave #(.CNT_W(CNT_W), .PWM_W(PWM_W), .OUT_REG(OUT_REG)) u_wave (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .cnt   (cnt),
      .duty  (duty),
      .per   (per),
      .pwm_o (pwm_out)
   );
endmodule

// File: tb/dual_byte_pwm_bench.sv
module dual_byte_pwm_bench;
   timeunit 1ns;
   timeprecision 100ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [15:0] wr_data = 16'h0;
   logic        tick = 1'b0;
   logic        pwm_out;

   int checks = 0;
   int fails  = 0;
   int act_hi = 0;
   int exp_hi = 0;

   // reference state taken from the requirements
   int m_en = 0, m_cnt = 0, m_p = 0, m_d = 0;

   always #2.5 clk = ~clk;

   dual_byte_pwm u_dual_byte_pwm (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .tick(tick), .pwm_out(pwm_out)
   );

   always @(negedge clk) if (pwm_out) act_hi = act_hi + 1;

   // {top count, high time, alternate ticks, enabled steps}
   localparam int NV = 13;
   localparam logic [39:0] VEC [NV] = '{
      {8'd9,   8'd5,   8'd0, 16'd30},
      {8'd9,   8'd1,   8'd0, 16'd40},
      {8'd9,   8'd9,   8'd0, 16'd25},
      {8'd9,   8'd10,  8'd0, 16'd30},
      {8'd9,   8'd200, 8'd0, 16'd30},
      {8'd0,   8'd1,   8'd0, 16'd20},
      {8'd0,   8'd0,   8'd0, 16'd20},
      {8'd50,  8'd0,   8'd0, 16'd120},
      {8'd255, 8'd100, 8'd0, 16'd530},
      {8'd255, 8'd255, 8'd0, 16'd515},
      {8'd254, 8'd255, 8'd0, 16'd300},
      {8'd3,   8'd2,   8'd1, 16'd37},
      {8'd1,   8'd1,   8'd1, 16'd21}
   };

   function automatic int lvl(int c);
      if (m_p == 0 || m_d == 0) return 0;
      if (m_d > m_p) return 1;
      return (c < m_d) ? 1 : 0;
   endfunction

   function automatic string tag_of(int p, int d, int alt);
      if (alt != 0) return "R2";
      if (p == 0) return "R5";
      if (d == 0) return "R6";
      if (d > p + 1) return "R9";
      if (d == p + 1) return "R8";
      if (p == 255) return "R7";
      return "R4";
   endfunction

   task automatic model_edge(input int t);
      if (m_en != 0) begin
         exp_hi = exp_hi + lvl(m_cnt);
         if (t != 0) m_cnt = (m_cnt == m_p) ? 0 : m_cnt + 1;
      end
   endtask

   task automatic chk(input bit ok, input string tag, input int a, input int e);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s: actual %0d expected %0d", tag, a, e);
      end
   endtask

   task automatic cyc(input int t);
      wr_en = 1'b0;
      tick  = (t != 0);
      @(posedge clk);
      model_edge(t);
      @(negedge clk);
   endtask

   task automatic wr(input int sel, input int data);
      wr_en   = 1'b1;
      wr_sel  = 2'(sel);
      wr_data = 16'(data);
      tick    = 1'b0;
      @(posedge clk);
      model_edge(0);
      case (sel)
         0: m_en  = data & 1;
         1: begin m_d = (data >> 8) & 255; m_p = data & 255; end
         2: m_cnt = data & 16'hFFFF;
         default: ;
      endcase
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic setup(input int p, input int d, input int c);
      wr(0, 0);
      wr(1, (d << 8) | p);
      wr(2, c);
      cyc(0);
      cyc(0);
      act_hi = 0;
      exp_hi = 0;
   endtask

   task automatic close_and_check(input string tag);
      wr(0, 0);
      cyc(0);
      cyc(0);
      chk(act_hi == exp_hi, tag, act_hi, exp_hi);
   endtask

   initial begin
      #1000000;
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(pwm_out == 1'b0, "R1", int'(pwm_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      act_hi = 0;
      exp_hi = 0;
      wr(0, 1);
      for (int i = 0; i < 20; i++) cyc(1);
      close_and_check("R1");

      // vector table
      for (int v = 0; v < NV; v++) begin
         int p, d, alt, n;
         p   = int'(VEC[v][39:32]);
         d   = int'(VEC[v][31:24]);
         alt = int'(VEC[v][23:16]);
         n   = int'(VEC[v][15:0]);
         setup(p, d, 0);
         wr(0, 1);
         for (int i = 0; i < n; i++) cyc((alt == 0) ? 1 : ((i % 2 == 0) ? 1 : 0));
         close_and_check(tag_of(p, d, alt));
      end

      // R11: registered output timing
      setup(9, 5, 0);
      wr(0, 1);
      chk(pwm_out == 1'b0, "R11", int'(pwm_out), 0);
      cyc(1);
      chk(pwm_out == 1'b1, "R11", int'(pwm_out), 1);
      for (int i = 0; i < 4; i++) cyc(1);
      chk(pwm_out == 1'b1, "R11", int'(pwm_out), 1);
      cyc(1);
      chk(pwm_out == 1'b0, "R11", int'(pwm_out), 0);
      close_and_check("R11");

      // R3: disable mid-period, hold, resume
      setup(9, 5, 0);
      wr(0, 1);
      for (int i = 0; i < 3; i++) cyc(1);
      wr(0, 0);
      for (int i = 0; i < 6; i++) cyc(1);
      chk(pwm_out == 1'b0, "R3", int'(pwm_out), 0);
      wr(0, 1);
      for (int i = 0; i < 12; i++) cyc(1);
      close_and_check("R3");

      // R10: counter load to a nonzero value
      setup(9, 5, 7);
      wr(0, 1);
      for (int i = 0; i < 13; i++) cyc(1);
      close_and_check("R10");

      // R10: reserved code is ignored while running
      setup(9, 5, 0);
      wr(0, 1);
      for (int i = 0; i < 4; i++) cyc(1);
      wr(3, 0);
      for (int i = 0; i < 8; i++) cyc(1);
      close_and_check("R10");

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule